// File: doc/BRIEF.md
# Memory Frequency Change Sequencer

This block runs a hardware-managed change of the DRAM clock. Software first loads new refresh timing into a shadow register while buffering is on. It then sets a start bit in the control register. The sequencer waits until every bus master that is not masked out reports ready. It can then hold the DRAM pads, if software asked for that. Next it moves the shadow timing into the active timing outputs and asks the clock generator to switch. When the switch is acknowledged, it releases the pads and clears the start bit.

Software polls the start bit, or the busy bit that mirrors it, until it reads 0. When buffering is off, timing writes go straight to the active outputs. The DRAM controller and the clock sources sit outside this block.

Top module: `mfc_seq_top`

## Requirements
- R1: After reset, the control, mask, shadow and active timing registers are all 0, and `pad_hold_o` and `sw_req_o` are low.
- R2: Control register (address 0) bit positions: bit 0 starts a sequence, bit 1 selects the switch mode, bit 4 enables bypass, bit 13 requests pad hold and bit 15 enables timing buffering. Bit 31 is a read-only busy flag equal to bit 0. `sw_mode_o` and `sw_bypass_o` follow bits 1 and 4.
- R3: Timing register (address 2) layout: the refresh interval is in bits 16 and up (12 bits), and the refresh cycle time is in bits 0 and up (10 bits). With buffering off, a write updates `trefi_o` and `trfc_o` on the next cycle, and a read returns the active value.
- R4: With buffering on, a timing write goes to the shadow only. The active outputs keep their value, and a read of address 2 returns the shadow.
- R5: After start, the sequence waits until, for every master i, `mst_rdy_i[i]` is 1 or bit i of the mask register (address 1, read back as written) is 1.
- R6: Once the masters are ready, `pad_hold_o` rises if bit 13 is set and stays high through the clock request. If bit 13 is clear, it stays low.
- R7: When buffering is on, the shadow timing is copied to the active outputs before `sw_req_o` rises. When buffering is off, no copy takes place.
- R8: `sw_req_o` stays high until `sw_ack_i`. The cycle after the ack, the pad hold is released, and start/busy clear one cycle later.
- R9: Control register writes made while busy are ignored, a start write included.
- R10: Writing 0 to the control register turns buffering off, so later timing writes reach the active outputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| mst_rdy_i | input | N_MST | Per-master ready |
| pad_hold_o | output | 1 | Hold DRAM pads |
| sw_req_o | output | 1 | Clock switch request |
| sw_ack_i | input | 1 | Clock switch acknowledge |
| sw_mode_o | output | 1 | Switch mode select |
| sw_bypass_o | output | 1 | Bypass enable |
| trefi_o | output | TREFI_W | Active refresh interval (units of 32 clocks) |
| trfc_o | output | TRFC_W | Active refresh cycle time (clocks) |

## Verification
Some rules are checked by assertions on every cycle. The request stays up until it is acknowledged, and the sequence does not leave the ready wait while an unmasked master is low. The pads stay held while a request is active with hold enabled, and they are already released when busy falls. A direct timing write lands in the active outputs, and control fields do not change during a busy write. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle order of release and completion, the absence of a copy with buffering off, the readback of shadow and mask, and the ignoring of a master that is masked out.

// File: rtl/mfc_pkg.sv
`timescale 1ns/1ps
package mfc_pkg;
  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_MASK   = 2'd1;
  localparam logic [1:0] A_TIMING = 2'd2;

  localparam int unsigned B_START = 0;
  localparam int unsigned B_MODE  = 1;
  localparam int unsigned B_BYP   = 4;
  localparam int unsigned B_HOLD  = 13;
  localparam int unsigned B_BUF   = 15;
  localparam int unsigned B_BUSY  = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_COPY, S_REQ, S_REL, S_FIN
  } seq_state_e;

  typedef struct packed {
    logic buf_en;
    logic hold_en;
    logic bypass;
    logic mode;
    logic start;
  } ctrl_t;
endpackage

// File: rtl/mfc_regs.sv
`timescale 1ns/1ps
module mfc_regs
  import mfc_pkg::*;
#(
  parameter int unsigned TREFI_W = 12,
  parameter int unsigned TRFC_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               copy_i,
  input  logic               clear_i,
  output ctrl_t              ctrl_o,
  output logic [31:0]        mask_o,
  output logic [TREFI_W-1:0] trefi_o,
  output logic [TRFC_W-1:0]  trfc_o
);
  localparam int unsigned TREFI_LSB = 16;
  localparam int unsigned PAD_HI    = 32 - TREFI_LSB - TREFI_W;
  localparam int unsigned PAD_LO    = TREFI_LSB - TRFC_W;

  ctrl_t              ctrl_q;
  logic [31:0]        mask_q;
  logic [TREFI_W-1:0] sh_trefi_q, act_trefi_q;
  logic [TRFC_W-1:0]  sh_trfc_q, act_trfc_q;
  logic [TREFI_W-1:0] w_trefi;
  logic [TRFC_W-1:0]  w_trfc;
  logic               wr_ctrl, wr_tim;

  assign w_trefi = wdata_i[TREFI_LSB +: TREFI_W];
  assign w_trfc  = wdata_i[0 +: TRFC_W];
  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_tim  = wr_en_i && addr_i == A_TIMING;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (clear_i) ctrl_q.start <= 1'b0;
      else if (wr_ctrl && !ctrl_q.start) begin
        ctrl_q.start   <= wdata_i[B_START];
        ctrl_q.mode    <= wdata_i[B_MODE];
        ctrl_q.bypass  <= wdata_i[B_BYP];
        ctrl_q.hold_en <= wdata_i[B_HOLD];
        ctrl_q.buf_en  <= wdata_i[B_BUF];
      end
      if (wr_en_i && addr_i == A_MASK) mask_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_trefi_q  <= '0;
      sh_trfc_q   <= '0;
      act_trefi_q <= '0;
      act_trfc_q  <= '0;
    end else begin
      if (wr_tim && ctrl_q.buf_en) begin
        sh_trefi_q <= w_trefi;
        sh_trfc_q  <= w_trfc;
      end
      if (copy_i) begin
        act_trefi_q <= sh_trefi_q;
        act_trfc_q  <= sh_trfc_q;
      end else if (wr_tim && !ctrl_q.buf_en) begin
        act_trefi_q <= w_trefi;
        act_trfc_q  <= w_trfc;
      end
    end
  end

  logic [31:0] ctrl_word;
  always_comb begin
    ctrl_word         = '0;
    ctrl_word[B_START] = ctrl_q.start;
    ctrl_word[B_MODE]  = ctrl_q.mode;
    ctrl_word[B_BYP]   = ctrl_q.bypass;
    ctrl_word[B_HOLD]  = ctrl_q.hold_en;
    ctrl_word[B_BUF]   = ctrl_q.buf_en;
    ctrl_word[B_BUSY]  = ctrl_q.start;
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = ctrl_word;
      A_MASK:   rdata_o = mask_q;
      A_TIMING: rdata_o = ctrl_q.buf_en
                  ? {{PAD_HI{1'b0}}, sh_trefi_q, {PAD_LO{1'b0}}, sh_trfc_q}
                  : {{PAD_HI{1'b0}}, act_trefi_q, {PAD_LO{1'b0}}, act_trfc_q};
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign mask_o  = mask_q;
  assign trefi_o = act_trefi_q;
  assign trfc_o  = act_trfc_q;

  // R3
  direct_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tim && !ctrl_q.buf_en && !copy_i) |=>
      (act_trefi_q == $past(w_trefi) && act_trfc_q == $past(w_trfc)));

  // R9
  busy_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && ctrl_q.start) |=>
      ({ctrl_q.buf_en, ctrl_q.hold_en, ctrl_q.bypass, ctrl_q.mode} ==
       $past({ctrl_q.buf_en, ctrl_q.hold_en, ctrl_q.bypass, ctrl_q.mode})));
endmodule

// File: rtl/mfc_fsm.sv
`timescale 1ns/1ps
module mfc_fsm
  import mfc_pkg::*;
#(
  parameter int unsigned N_MST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hold_en_i,
  input  logic             buf_en_i,
  input  logic [N_MST-1:0] mst_rdy_i,
  input  logic [N_MST-1:0] mask_i,
  input  logic             sw_ack_i,
  output logic             sw_req_o,
  output logic             pad_hold_o,
  output logic             copy_o,
  output logic             clear_o
);
  seq_state_e state_q, state_d;
  logic       pad_q;
  logic       rdy_ok;

  assign rdy_ok = &(mst_rdy_i | mask_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_WAIT;
      S_WAIT: if (rdy_ok) state_d = S_COPY;
      S_COPY: state_d = S_REQ;
      S_REQ:  if (sw_ack_i) state_d = S_REL;
      S_REL:  state_d = S_FIN;
      S_FIN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_WAIT && rdy_ok) pad_q <= hold_en_i;
      else if (state_q == S_REL)       pad_q <= 1'b0;
    end
  end

  assign sw_req_o   = state_q == S_REQ;
  assign pad_hold_o = pad_q;
  assign copy_o     = state_q == S_COPY && buf_en_i;
  assign clear_o    = state_q == S_FIN;

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req_o && !sw_ack_i) |=> sw_req_o);

  // R5
  wait_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !rdy_ok) |=> state_q == S_WAIT);

  // R6
  hold_during_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req_o && hold_en_i) |-> pad_hold_o);

  // R8
  pad_before_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_i) |-> !pad_hold_o);
endmodule

// File: rtl/mfc_seq_top.sv
`timescale 1ns/1ps
module mfc_seq_top
  import mfc_pkg::*;
#(
  parameter int unsigned N_MST   = 4,
  parameter int unsigned TREFI_W = 12,
  parameter int unsigned TRFC_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [N_MST-1:0]   mst_rdy_i,
  output logic               pad_hold_o,
  output logic               sw_req_o,
  input  logic               sw_ack_i,
  output logic               sw_mode_o,
  output logic               sw_bypass_o,
  output logic [TREFI_W-1:0] trefi_o,
  output logic [TRFC_W-1:0]  trfc_o
);
  ctrl_t       ctrl;
  logic [31:0] mask;
  logic        copy, clear;

  mfc_regs #(.TREFI_W(TREFI_W), .TRFC_W(TRFC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .copy_i(copy), .clear_i(clear), .ctrl_o(ctrl), .mask_o(mask),
    .trefi_o, .trfc_o
  );

  mfc_fsm #(.N_MST(N_MST)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(ctrl.start), .hold_en_i(ctrl.hold_en), .buf_en_i(ctrl.buf_en),
    .mst_rdy_i, .mask_i(mask[N_MST-1:0]), .sw_ack_i,
    .sw_req_o, .pad_hold_o, .copy_o(copy), .clear_o(clear)
  );

  assign sw_mode_o   = ctrl.mode;
  assign sw_bypass_o = ctrl.bypass;

  // R7
  copy_before_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_req_o) |-> (ctrl.buf_en ? $past(copy) : !$past(copy)));
endmodule

// File: tb/tb_mfc_seq_top.sv
`timescale 1ns/1ps
module tb_mfc_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  rdy = '0;
  logic        pad, req, ack = 1'b0, mode, byp;
  logic [11:0] trefi;
  logic [9:0]  trfc;

  mfc_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mst_rdy_i(rdy), .pad_hold_o(pad),
    .sw_req_o(req), .sw_ack_i(ack), .sw_mode_o(mode), .sw_bypass_o(byp),
    .trefi_o(trefi), .trfc_o(trfc)
  );

  always #10 clk = ~clk;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;
  item_t item_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] pack(int ti, int tc);
    return (32'(ti) << 16) | 32'(tc);
  endfunction

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return rdata;
      1: return {28'd0, byp, mode, req, pad};
      default: return {4'd0, trefi, 6'd0, trfc};
    endcase
  endfunction

  // monitor
  initial forever begin
    @(negedge clk);
    while (item_q.size() > 0) begin
      item_t it;
      logic [31:0] obs;
      it  = item_q.pop_front();
      obs = observe(it.sel);
      n_cmp++;
      if (obs !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, obs, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_val(string tag, int sel, logic [1:0] a, logic [31:0] e);
    if (sel == 0) addr = a;
    item_q.push_back('{tag, sel, e});
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 40; i++) begin
      if (req) break;
      tick();
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_val("R1 ctrl", 0, 2'd0, 32'h0);
    expect_val("R1 outs", 1, 2'd0, 32'h0);
    expect_val("R1 timing", 2, 2'd0, 32'h0);
    tick();

    wr(2'd2, pack(100, 20));
    expect_val("R3 direct active", 2, 2'd0, pack(100, 20));
    expect_val("R3 readback", 0, 2'd2, pack(100, 20));
    tick();

    wr(2'd0, 32'h0000_A002);
    expect_val("R2 ctrl read", 0, 2'd0, 32'h0000_A002);
    expect_val("R2 mode out", 1, 2'd0, 32'h4);
    tick();

    wr(2'd2, pack(200, 40));
    expect_val("R4 active kept", 2, 2'd0, pack(100, 20));
    expect_val("R4 shadow read", 0, 2'd2, pack(200, 40));
    tick();

    rdy = 4'b1011;
    wr(2'd0, 32'h0000_A003);
    repeat (20) tick();
    expect_val("R5 blocked no req", 1, 2'd0, 32'h4);
    expect_val("R5 busy", 0, 2'd0, 32'h8000_A003);
    expect_val("R7 no early copy", 2, 2'd0, pack(100, 20));
    tick();

    rdy = 4'b1111;
    wait_req();
    expect_val("R6 hold with req", 1, 2'd0, 32'h7);
    expect_val("R7 copied", 2, 2'd0, pack(200, 40));
    tick();

    wr(2'd0, 32'h0000_0001);
    expect_val("R9 ctrl ignored", 0, 2'd0, 32'h8000_A003);
    expect_val("R8 req held", 1, 2'd0, 32'h7);
    tick();

    ack = 1'b1;
    tick();
    ack = 1'b0;
    expect_val("R8 req drop pad held", 1, 2'd0, 32'h5);
    tick();
    expect_val("R8 pad released", 1, 2'd0, 32'h4);
    expect_val("R8 still busy", 0, 2'd0, 32'h8000_A003);
    tick();
    expect_val("R8 start cleared", 0, 2'd0, 32'h0000_A002);
    tick();

    wr(2'd0, 32'h0);
    wr(2'd2, pack(300, 60));
    expect_val("R10 direct after clear", 2, 2'd0, pack(300, 60));
    expect_val("R10 ctrl zero", 0, 2'd0, 32'h0);
    tick();

    rdy = 4'b1011;
    wr(2'd1, 32'h4);
    expect_val("R5 mask read", 0, 2'd1, 32'h4);
    tick();
    wr(2'd0, 32'h0000_0011);
    wait_req();
    expect_val("R6 R5 masked no hold", 1, 2'd0, 32'hA);
    expect_val("R7 no copy unbuffered", 2, 2'd0, pack(300, 60));
    tick();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    tick();
    tick();
    expect_val("R2 R8 done ctrl", 0, 2'd0, 32'h0000_0010);
    tick();
    tick();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule